// File: doc/BRIEF.md
# Reset Cause and Source Controller

This block merges every reset request of a chip into one system reset and remembers which event caused the most recent one. Its 8-bit register answers on a small register bus. A normal read returns the latched cause flags. Writing the register sets which optional reset sources are armed, and a read-modify-write access reads back those armed enables in place of the flags, so software can change one enable without disturbing the others.

The inputs are the external pin reset, a power-on reset and a supply-monitor event, a watchdog timeout, a missing-clock timeout, a flash fault, an active-low comparator level, and a real-time-clock alarm or oscillator-fail event. All of them arrive as synchronous signals. When a qualified event fires, the block clears all cause flags and sets only the flag of the winning source. It then drives the system reset for a fixed number of cycles. Software can also start a reset by writing a 1 to the force bit.

Top module: `rstcause_ctrl`

## Requirements
- R1: Cause flag positions are bit7 clock alarm/osc fail, bit6 flash fault, bit5 comparator, bit4 software force, bit3 watchdog, bit2 missing clock, bit1 power-on/supply monitor, bit0 pin. After any reset, exactly one flag is set: the one for the source that caused it.
- R2: A read at the register address with rmw low returns the flags. With rmw high it returns {en7, flag6, en5, 0, flag3, en2, en1, flag0}, where enN is the armed enable of bit N.
- R3: `sys_rst_o` rises on the clock edge that registers a qualified event and stays high for exactly STRETCH_CYC cycles. During power-on it stays high, and it holds for STRETCH_CYC cycles after `por_i` falls.
- R4: Power-on sets the flags to 0x02 and the enables so that only en1 is set.
- R5: Pin reset, watchdog timeout and flash fault always cause a reset.
- R6: A clock-alarm event resets only when en7 is 1. A missing-clock event resets only when en2 is 1. Otherwise each is ignored.
- R7: The comparator input is active-low. A low level resets only when en5 is 1.
- R8: A supply-monitor event resets only when en1 is 1.
- R9: Writing 1 to bit4 starts a reset that records the software flag. Writing 0 to bit4 starts no reset.
- R10: When sources fire in the same cycle, the winner is chosen in this order: supply monitor, then pin, then bits 7, 6, 5, 4, 3, 2.
- R11: A write loads en7, en5, en2 and en1 from the data bits of the same position and ignores bits 6, 3 and 0. Enables keep their values across every reset except power-on.
- R12: Events and register writes that arrive while `sys_rst_o` is high are ignored.
- R13: Accesses at any address other than REG_ADDR change nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| pin_rst_i | input | 1 | External pin reset request |
| supply_evt_i | input | 1 | Supply-monitor trip |
| wdt_evt_i | input | 1 | Watchdog timeout |
| mcd_evt_i | input | 1 | Missing-clock timeout |
| flash_err_i | input | 1 | Flash access fault |
| cmp_n_i | input | 1 | Comparator level, active low |
| rtc_evt_i | input | 1 | Clock alarm or oscillator fail |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rmw_i | input | 1 | Access is read-modify-write |
| bus_rdata_o | output | 8 | Read data |
| sys_rst_o | output | 1 | System reset |

## Verification
The bench uses the default parameters: a STRETCH_CYC of 16, an 8-bit address and a register address of 0xEF. With these values it measures the exact length of every reset pulse, which brings the off-by-one edges of the stretch counter within reach. The address value lets the bench separate a decoded access from a near miss. With this setup the bench drives each source alone, both with its enable armed and with it disarmed, and drives mixed same-cycle collisions. It also drives requests and writes that land inside a running pulse.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    localparam int FLAG_W = 8;

    localparam int BIT_RTC    = 7;
    localparam int BIT_FLASH  = 6;
    localparam int BIT_CMP    = 5;
    localparam int BIT_SW     = 4;
    localparam int BIT_WDT    = 3;
    localparam int BIT_MCD    = 2;
    localparam int BIT_SUPPLY = 1;
    localparam int BIT_PIN    = 0;

    // Sources that reset without any enable.
    localparam logic [FLAG_W-1:0] ALWAYS_MASK = 8'b0101_1001;
    // Bits that software can arm.
    localparam logic [FLAG_W-1:0] ENAB_MASK   = 8'b1010_0110;
    localparam logic [FLAG_W-1:0] FLAGS_POR   = 8'b0000_0010;
    localparam logic [FLAG_W-1:0] ENAB_POR    = 8'b0000_0010;

    // Member order matches flag bit positions, MSB first.
    typedef struct packed {
        logic rtc;
        logic flash;
        logic cmp;
        logic sw;
        logic wdt;
        logic mcd;
        logic supply;
        logic pin;
    } src_evt_t;

    // Priority pick: supply monitor, pin, then bit 7 down to bit 2.
    function automatic logic [FLAG_W-1:0] pick_cause(input logic [FLAG_W-1:0] req);
        logic [FLAG_W-1:0] g;
        g = '0;
        if (req[BIT_SUPPLY]) begin
            g[BIT_SUPPLY] = 1'b1;
        end else if (req[BIT_PIN]) begin
            g[BIT_PIN] = 1'b1;
        end else begin
            for (int i = BIT_MCD; i <= BIT_RTC; i++) begin
                if (req[i]) begin
                    g = '0;
                    g[i] = 1'b1;
                end
            end
        end
        return g;
    endfunction

    // Read-modify-write view: enables on armable bits, flags on read-only bits.
    function automatic logic [FLAG_W-1:0] rmw_view(input logic [FLAG_W-1:0] flags,
                                                   input logic [FLAG_W-1:0] enab);
        return (enab & ENAB_MASK) | (flags & ALWAYS_MASK & ~(FLAG_W'(1) << BIT_SW));
    endfunction

endpackage

// File: rtl/rstcause_qualify.sv
module rstcause_qualify
    import rstcause_pkg::*;
(
    input  src_evt_t          raw_i,
    input  logic [FLAG_W-1:0] enab_i,
    output logic [FLAG_W-1:0] req_o
);
    always_comb begin
        req_o = raw_i & (enab_i | ALWAYS_MASK);
    end
endmodule

// File: rtl/rstcause_stretch.sv
module rstcause_stretch #(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic por_i,
    input  logic trig_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(STRETCH_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            cnt_q <= LOAD;
        end else if (trig_i) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rstcause_regfile.sv
module rstcause_regfile
    import rstcause_pkg::*;
(
    input  logic              clk,
    input  logic              por_i,
    input  logic              wr_i,
    input  logic [FLAG_W-1:0] wdata_i,
    input  logic              trig_i,
    input  logic [FLAG_W-1:0] grant_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] enab_o
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] enab_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            flags_q <= FLAGS_POR;
        end else if (trig_i) begin
            flags_q <= grant_i;
        end
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            enab_q <= ENAB_POR;
        end else if (wr_i) begin
            enab_q <= wdata_i & ENAB_MASK;
        end
    end

    assign flags_o = flags_q;
    assign enab_o  = enab_q;
endmodule

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
    import rstcause_pkg::*;
#(
    parameter int          STRETCH_CYC = 16,
    parameter int          ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              pin_rst_i,
    input  logic              supply_evt_i,
    input  logic              wdt_evt_i,
    input  logic              mcd_evt_i,
    input  logic              flash_err_i,
    input  logic              cmp_n_i,
    input  logic              rtc_evt_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    input  logic              bus_rmw_i,
    output logic [7:0]        bus_rdata_o,
    output logic              sys_rst_o
);
    logic              sel;
    logic              wr_ok;
    src_evt_t          raw;
    logic [FLAG_W-1:0] req;
    logic [FLAG_W-1:0] grant;
    logic              trig;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] enab_q;
    logic              busy;

    assign sel   = (bus_addr_i == REG_ADDR);
    assign wr_ok = bus_wr_i && sel && !busy && !por_i;

    always_comb begin
        raw        = '0;
        raw.rtc    = rtc_evt_i;
        raw.flash  = flash_err_i;
        raw.cmp    = !cmp_n_i;
        raw.sw     = wr_ok && bus_wdata_i[BIT_SW];
        raw.wdt    = wdt_evt_i;
        raw.mcd    = mcd_evt_i;
        raw.supply = supply_evt_i;
        raw.pin    = pin_rst_i;
    end

    rstcause_qualify u_qual (
        .raw_i  (raw),
        .enab_i (enab_q),
        .req_o  (req)
    );

    assign grant = pick_cause(req);
    assign trig  = (|req) && !busy && !por_i;

    rstcause_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk      (clk),
        .por_i    (por_i),
        .trig_i   (trig),
        .active_o (busy)
    );

    rstcause_regfile u_regs (
        .clk     (clk),
        .por_i   (por_i),
        .wr_i    (wr_ok),
        .wdata_i (bus_wdata_i),
        .trig_i  (trig),
        .grant_i (grant),
        .flags_o (flags_q),
        .enab_o  (enab_q)
    );

    always_comb begin
        if (!sel) begin
            bus_rdata_o = '0;
        end else if (bus_rmw_i) begin
            bus_rdata_o = rmw_view(flags_q, enab_q);
        end else begin
            bus_rdata_o = flags_q;
        end
    end

    assign sys_rst_o = busy;
endmodule

// File: rtl/rstcause_ctrl_chk.sv
module rstcause_ctrl_chk #(
    parameter int STRETCH_CYC = 16,
    parameter int ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
    input logic              clk,
    input logic              por_i,
    input logic              sys_rst_o,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [7:0]        bus_wdata_i,
    input logic              pin_rst_i,
    input logic              wdt_evt_i,
    input logic              flash_err_i,
    input logic [7:0]        flags_q,
    input logic [7:0]        enab_q
);
    localparam int RUN_W = $clog2(STRETCH_CYC + 1) + 1;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            run_q <= '0;
        end else if (sys_rst_o) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (por_i)
        run_q <= RUN_W'(STRETCH_CYC));

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> run_q == RUN_W'(STRETCH_CYC));

    assert_por_state_R4: assert property (@(posedge clk)
        por_i |=> (flags_q == 8'h02) && (enab_q == 8'h02));

    assert_one_cause_R1: assert property (@(posedge clk) disable iff (por_i)
        $onehot0(flags_q) && (flags_q != 8'h00));

    assert_always_src_R5: assert property (@(posedge clk) disable iff (por_i)
        (pin_rst_i || wdt_evt_i || flash_err_i) && !sys_rst_o |=> sys_rst_o);

    assert_sw_force_R9: assert property (@(posedge clk) disable iff (por_i)
        bus_wr_i && (bus_addr_i == REG_ADDR) && bus_wdata_i[4] && !sys_rst_o |=> sys_rst_o);

    assert_frozen_R12: assert property (@(posedge clk) disable iff (por_i)
        sys_rst_o |=> $stable(enab_q) && $stable(flags_q));
endmodule

bind rstcause_ctrl rstcause_ctrl_chk #(
    .STRETCH_CYC (STRETCH_CYC),
    .ADDR_W      (ADDR_W),
    .REG_ADDR    (REG_ADDR)
) u_chk (
    .clk         (clk),
    .por_i       (por_i),
    .sys_rst_o   (sys_rst_o),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pin_rst_i   (pin_rst_i),
    .wdt_evt_i   (wdt_evt_i),
    .flash_err_i (flash_err_i),
    .flags_q     (flags_q),
    .enab_q      (enab_q)
);

// File: tb/rstcause_ctrl_test.sv
`timescale 1ns/1ps
module rstcause_ctrl_test;
    localparam int  STRETCH = 16;
    localparam logic [7:0] RADDR = 8'hEF;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       pin = 1'b0, sup = 1'b0, wdt = 1'b0, mcd = 1'b0;
    logic       fl = 1'b0, cmp_n = 1'b1, rtc = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rmw = 1'b0;
    logic [7:0] rdata;
    logic       srst;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    rstcause_ctrl uut (
        .clk(clk), .por_i(por), .pin_rst_i(pin), .supply_evt_i(sup),
        .wdt_evt_i(wdt), .mcd_evt_i(mcd), .flash_err_i(fl), .cmp_n_i(cmp_n),
        .rtc_evt_i(rtc), .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rmw_i(rmw), .bus_rdata_o(rdata), .sys_rst_o(srst)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        pin = 0; sup = 0; wdt = 0; mcd = 0; fl = 0; cmp_n = 1; rtc = 0;
        wr = 0; wdata = 8'h00; rmw = 0; addr = RADDR;
    endtask

    task automatic read_reg(input logic [7:0] a, input logic m, output logic [7:0] d);
        addr = a; rmw = m; #1; d = rdata; rmw = 0; addr = RADDR;
    endtask

    // Inputs are set at a negedge by the caller; this lets the edge register them.
    task automatic expect_reset(input string req, input logic [7:0] exp_flags);
        logic [7:0] d;
        int n;
        @(posedge clk); @(negedge clk);
        clear_in();
        n = 0;
        while (srst && n < 100) begin
            n++;
            @(negedge clk);
        end
        check({req, " pulse length"}, n, STRETCH);
        read_reg(RADDR, 1'b0, d);
        check({req, " cause flags"}, d, exp_flags);
    endtask

    task automatic expect_quiet(input string req, input logic [7:0] exp_flags);
        logic [7:0] d;
        int hi;
        @(posedge clk); @(negedge clk);
        clear_in();
        hi = 0;
        for (int i = 0; i < 3; i++) begin
            if (srst) hi++;
            @(negedge clk);
        end
        check({req, " no reset"}, hi, 0);
        read_reg(RADDR, 1'b0, d);
        check({req, " flags kept"}, d, exp_flags);
    endtask

    task automatic write_quiet(input logic [7:0] v);
        @(negedge clk);
        addr = RADDR; wr = 1; wdata = v;
        @(posedge clk); @(negedge clk);
        clear_in();
    endtask

    task automatic t_power_on();
        logic [7:0] d;
        int n;
        @(negedge clk); por = 1; clear_in();
        repeat (2) @(negedge clk);
        por = 0;
        n = 0;
        while (srst && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R3 power-on pulse length", n, STRETCH);
        read_reg(RADDR, 1'b0, d);
        check("R4 power-on flags", d, 8'h02);
        read_reg(RADDR, 1'b1, d);
        check("R4 power-on enables", d, 8'h02);
    endtask

    task automatic t_always_sources();
        logic [7:0] d;
        @(negedge clk); pin = 1; expect_reset("R5 pin", 8'h01);
        read_reg(RADDR, 1'b1, d);
        check("R2 rmw view after pin", d, 8'h03);
        @(negedge clk); wdt = 1; expect_reset("R5 watchdog", 8'h08);
        @(negedge clk); fl = 1;  expect_reset("R5 flash", 8'h40);
    endtask

    task automatic t_gated_off();
        @(negedge clk); mcd = 1;   expect_quiet("R6 mcd disarmed", 8'h40);
        @(negedge clk); rtc = 1;   expect_quiet("R6 rtc disarmed", 8'h40);
        @(negedge clk); cmp_n = 0; expect_quiet("R7 cmp disarmed", 8'h40);
    endtask

    task automatic t_arm_and_fire();
        logic [7:0] d;
        @(negedge clk); addr = RADDR; wr = 1; wdata = 8'hEF;
        expect_quiet("R11 write no reset", 8'h40);
        read_reg(RADDR, 1'b1, d);
        check("R11 enables loaded, read-only ignored", d, 8'hE6);
        @(negedge clk); rtc = 1;   expect_reset("R6 rtc armed", 8'h80);
        @(negedge clk); mcd = 1;   expect_reset("R6 mcd armed", 8'h04);
        @(negedge clk); cmp_n = 0; expect_reset("R7 cmp low armed", 8'h20);
        @(negedge clk); sup = 1;   expect_reset("R8 supply armed", 8'h02);
        read_reg(RADDR, 1'b1, d);
        check("R11 enables retained", d, 8'hA6);
    endtask

    task automatic t_soft_force();
        logic [7:0] d;
        @(negedge clk); addr = RADDR; wr = 1; wdata = 8'hB6;
        expect_reset("R9 force write", 8'h10);
        read_reg(RADDR, 1'b1, d);
        check("R2 rmw hides soft flag", d, 8'hA6);
        @(negedge clk); addr = RADDR; wr = 1; wdata = 8'hA6;
        expect_quiet("R9 zero write", 8'h10);
    endtask

    task automatic t_priority();
        @(negedge clk); pin = 1; wdt = 1; rtc = 1;
        expect_reset("R10 pin over wdt/rtc", 8'h01);
        @(negedge clk); rtc = 1; fl = 1; cmp_n = 0;
        expect_reset("R10 rtc over flash/cmp", 8'h80);
        @(negedge clk); sup = 1; pin = 1; wdt = 1;
        expect_reset("R10 supply over pin", 8'h02);
        @(negedge clk); mcd = 1; wdt = 1;
        expect_reset("R10 wdt over mcd", 8'h08);
    endtask

    task automatic t_supply_off_and_addr();
        logic [7:0] d;
        write_quiet(8'hA4);
        @(negedge clk); sup = 1; expect_quiet("R8 supply disarmed", 8'h08);
        @(negedge clk); addr = 8'h12; wr = 1; wdata = 8'h10;
        expect_quiet("R13 foreign write", 8'h08);
        read_reg(8'h12, 1'b0, d);
        check("R13 foreign read", d, 8'h00);
        read_reg(8'hEE, 1'b1, d);
        check("R13 near-miss read", d, 8'h00);
    endtask

    task automatic t_during_reset();
        logic [7:0] d;
        int n;
        @(negedge clk); wdt = 1;
        @(posedge clk); @(negedge clk);
        clear_in();
        pin = 1; addr = RADDR; wr = 1; wdata = 8'h10;
        n = 1;
        @(posedge clk); @(negedge clk);
        clear_in();
        while (srst && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R12 pulse not extended", n, STRETCH);
        read_reg(RADDR, 1'b0, d);
        check("R12 late pin ignored", d, 8'h08);
        read_reg(RADDR, 1'b1, d);
        check("R12 write ignored", d, 8'hAC);
        @(negedge clk);
        check("R12 no follow-on reset", srst, 0);
    endtask

    initial begin
        clear_in();
        t_power_on();
        t_always_sources();
        t_gated_off();
        t_arm_and_fire();
        t_soft_force();
        t_priority();
        t_supply_off_and_addr();
        t_during_reset();
        t_power_on();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule